// File: doc/BRIEF.md
# Match Timer with Watchdog Reset

This block is an operating-system style timer for a processor subsystem. It is built around one free-running 32-bit up-counter that advances by one on every clock cycle in which the tick-enable input is high. Software can load the counter at any time. Four compare channels each hold a 32-bit match value. When the counter steps onto a channel's match value and that channel's interrupt is enabled, the channel records an event. The event drives the channel's own interrupt line until software clears it.

Compare channel 3 can also act as a watchdog. If the watchdog arm bit is set when that channel matches, the block emits a one-cycle system reset request and disarms itself. A small register bus with separate write and read strobes gives access to the counter, the match values, the event status, the interrupt enables and the watchdog arm register. Read data comes back one cycle after the read strobe. A read from an offset that holds no register returns zero and raises an error flag for that cycle.

Top module: `wdogMatchTimer`

## Requirements
- R1: After reset the counter, all match values, the status register, the interrupt enables and the watchdog register read as zero, and `irq` and `resetReq` are low.
- R2: Each clock edge with `tickEn` high adds one to the counter, which wraps from 0xFFFFFFFF to 0. A write to offset 0x10 loads the counter, and counting then continues from the loaded value. If a load and a tick happen in the same cycle, the load wins.
- R3: When a tick moves the counter onto the value held at offset 4*n (n = 0..3) and interrupt-enable bit n is 1, status bit n (offset 0x14) and `irq[n]` go high at that same edge. Loading the counter directly with the match value does not count as a match.
- R4: When interrupt-enable bit n is 0, a match on channel n leaves status bit n and `irq[n]` at 0.
- R5: A channel whose match value is 0 fires when the counter wraps from 0xFFFFFFFF to 0.
- R6: A write to offset 0x14 clears exactly those status bits that are written as 1 and are currently set. Every other bit keeps its value, and `irq[n]` always follows status bit n.
- R7: When channel 3 matches while bit 0 of the watchdog register (offset 0x18) is 1, `resetReq` is high for exactly one cycle at that edge and the watchdog register becomes 0. This happens whatever the state of interrupt-enable bit 3. When bit 0 is 0, no request is issued.
- R8: A write to the interrupt-enable register (offset 0x1C) keeps only bits 11:0. The upper bits read back as 0.
- R9: `rdData` holds the addressed register in the cycle after `rdEn`, and `rdErr` is low for mapped offsets. For an unmapped or misaligned offset, `rdData` is 0 and `rdErr` is high for that one cycle only.
- R10: Each match register stores and reads back the full 32-bit written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Counter advance enable, one count per cycle |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, valid the cycle after `rdEn` |
| rdErr | output | 1 | One-cycle flag for a read of an unmapped offset |
| irq | output | 4 | Per-channel interrupt lines, equal to the status bits |
| resetReq | output | 1 | One-cycle watchdog reset request |

## Verification
The bench builds the block with its default parameters: a 32-bit counter, four channels, 8-bit offsets, 12 interrupt-enable bits and the watchdog on channel 3. With these defaults the bench can load the counter a few counts below each match, so every match edge is reached in a handful of ticks. Loading 0xFFFFFFFE puts the 32-bit wrap within two ticks, which lets the bench check the match at zero. The 12-bit enable register is wider than the four channels, so the write mask can be seen on its own.

// File: rtl/wmtPkg.sv
package wmtPkg;
  // width of the channel index carried in the strobe struct (up to 16 channels)
  localparam int IDX_W = 4;

  typedef struct packed {
    logic             loadCount;
    logic             loadMatch;
    logic [IDX_W-1:0] matchIdx;
    logic             clearStatus;
    logic             loadIntEn;
    logic             loadWdog;
  } strobe_t;
endpackage

// File: rtl/wmtDatapath.sv
module wmtDatapath
  import wmtPkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NUM_CH  = 4,
  parameter int IEN_W   = 12,
  parameter int WDOG_CH = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     tickEn,
  input  strobe_t                  strb,
  input  logic [DATA_W-1:0]        wrData,
  output logic [DATA_W-1:0]        countVal,
  output logic [NUM_CH*DATA_W-1:0] matchFlat,
  output logic [NUM_CH-1:0]        statusVal,
  output logic [IEN_W-1:0]         intEnVal,
  output logic [DATA_W-1:0]        wdogVal,
  output logic                     resetReq
);
  logic [DATA_W-1:0] nextCount;
  logic              stepping;
  logic [NUM_CH-1:0] hit;
  logic [NUM_CH-1:0] clrMask;
  logic              wdogFire;

  assign nextCount = countVal + DATA_W'(1);
  assign stepping  = tickEn && !strb.loadCount;

  // counter: a load takes priority over a tick
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               countVal <= '0;
    else if (strb.loadCount) countVal <= wrData;
    else if (tickEn)         countVal <= nextCount;
  end

  // compare channels: match fires when the counter steps onto the value
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gCh
    logic [DATA_W-1:0] matchReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) matchReg <= '0;
      else if (strb.loadMatch && strb.matchIdx == IDX_W'(ch)) matchReg <= wrData;
    end
    assign hit[ch] = stepping && (nextCount == matchReg);
    assign matchFlat[ch*DATA_W +: DATA_W] = matchReg;
  end

  // status: write-one-to-clear on set bits only; a new event wins over a clear
  assign clrMask = strb.clearStatus ? (wrData[NUM_CH-1:0] & statusVal) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusVal <= '0;
    else       statusVal <= (statusVal & ~clrMask) | (hit & intEnVal[NUM_CH-1:0]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               intEnVal <= '0;
    else if (strb.loadIntEn) intEnVal <= wrData[IEN_W-1:0];
  end

  // watchdog: fire disarms the register, ahead of any software write
  assign wdogFire = hit[WDOG_CH] && wdogVal[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdogVal  <= '0;
      resetReq <= 1'b0;
    end else begin
      resetReq <= wdogFire;
      if (wdogFire)          wdogVal <= '0;
      else if (strb.loadWdog) wdogVal <= wrData;
    end
  end
endmodule

// File: rtl/wmtControl.sv
module wmtControl
  import wmtPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8,
  parameter int IEN_W  = 12
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic                     rdEn,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        countVal,
  input  logic [NUM_CH*DATA_W-1:0] matchFlat,
  input  logic [NUM_CH-1:0]        statusVal,
  input  logic [IEN_W-1:0]         intEnVal,
  input  logic [DATA_W-1:0]        wdogVal,
  output strobe_t                  strb,
  output logic [DATA_W-1:0]        rdData,
  output logic                     rdErr
);
  localparam int WIDX_W = ADDR_W - 2;
  localparam logic [WIDX_W-1:0] CNT_IDX  = WIDX_W'(NUM_CH);
  localparam logic [WIDX_W-1:0] STAT_IDX = WIDX_W'(NUM_CH + 1);
  localparam logic [WIDX_W-1:0] WDOG_IDX = WIDX_W'(NUM_CH + 2);
  localparam logic [WIDX_W-1:0] IEN_IDX  = WIDX_W'(NUM_CH + 3);

  logic [WIDX_W-1:0] wordIdx;
  logic aligned, isMatch, isCnt, isStat, isWdog, isIen, mapped;
  logic [DATA_W-1:0] rdMux;

  assign wordIdx = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);
  assign isMatch = aligned && (wordIdx < CNT_IDX);
  assign isCnt   = aligned && (wordIdx == CNT_IDX);
  assign isStat  = aligned && (wordIdx == STAT_IDX);
  assign isWdog  = aligned && (wordIdx == WDOG_IDX);
  assign isIen   = aligned && (wordIdx == IEN_IDX);
  assign mapped  = isMatch || isCnt || isStat || isWdog || isIen;

  always_comb begin
    strb             = '0;
    strb.loadCount   = wrEn && isCnt;
    strb.loadMatch   = wrEn && isMatch;
    strb.matchIdx    = wordIdx[IDX_W-1:0];
    strb.clearStatus = wrEn && isStat;
    strb.loadIntEn   = wrEn && isIen;
    strb.loadWdog    = wrEn && isWdog;
  end

  always_comb begin
    rdMux = '0;
    if (isCnt)  rdMux = countVal;
    if (isStat) rdMux = DATA_W'(statusVal);
    if (isWdog) rdMux = wdogVal;
    if (isIen)  rdMux = DATA_W'(intEnVal);
    for (int i = 0; i < NUM_CH; i++)
      if (isMatch && wordIdx == WIDX_W'(i)) rdMux = matchFlat[i*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
      rdErr  <= 1'b0;
    end else begin
      rdData <= rdEn ? rdMux : '0;
      rdErr  <= rdEn && !mapped;
    end
  end
endmodule

// File: rtl/wdogMatchTimer.sv
module wdogMatchTimer
  import wmtPkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NUM_CH  = 4,
  parameter int ADDR_W  = 8,
  parameter int IEN_W   = 12,
  parameter int WDOG_CH = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdErr,
  output logic [NUM_CH-1:0] irq,
  output logic              resetReq
);
  strobe_t                  strb;
  logic [DATA_W-1:0]        countVal;
  logic [NUM_CH*DATA_W-1:0] matchFlat;
  logic [NUM_CH-1:0]        statusVal;
  logic [IEN_W-1:0]         intEnVal;
  logic [DATA_W-1:0]        wdogVal;

  wmtControl #(.DATA_W(DATA_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .IEN_W(IEN_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .countVal(countVal), .matchFlat(matchFlat), .statusVal(statusVal),
    .intEnVal(intEnVal), .wdogVal(wdogVal),
    .strb(strb), .rdData(rdData), .rdErr(rdErr)
  );

  wmtDatapath #(.DATA_W(DATA_W), .NUM_CH(NUM_CH), .IEN_W(IEN_W), .WDOG_CH(WDOG_CH)) uDp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .strb(strb), .wrData(wrData),
    .countVal(countVal), .matchFlat(matchFlat), .statusVal(statusVal),
    .intEnVal(intEnVal), .wdogVal(wdogVal), .resetReq(resetReq)
  );

  assign irq = statusVal;
endmodule

// File: rtl/wmtChecker.sv
module wmtChecker #(
  parameter int DATA_W = 32,
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic              loadCnt,
  input logic [DATA_W-1:0] countVal,
  input logic              rdEn,
  input logic [DATA_W-1:0] rdData,
  input logic              rdErr,
  input logic [NUM_CH-1:0] irq,
  input logic              resetReq,
  input logic [DATA_W-1:0] wdogVal
);
  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !loadCnt) |=> countVal == $past(countVal) + DATA_W'(1));

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !loadCnt) |=> $stable(countVal));

  // R3
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(irq & ~$past(irq))) |-> $past(tickEn));

  // R7
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq);

  // R7
  wdog_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> wdogVal == '0);

  // R9
  err_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdErr |-> $past(rdEn));

  // R9
  err_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdErr |-> rdData == '0);
endmodule

bind wdogMatchTimer wmtChecker #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) uChk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .loadCnt(strb.loadCount),
  .countVal(countVal), .rdEn(rdEn), .rdData(rdData), .rdErr(rdErr),
  .irq(irq), .resetReq(resetReq), .wdogVal(wdogVal)
);

// File: tb/sim_wdogMatchTimer.sv
module sim_wdogMatchTimer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        rdErr;
  logic [3:0]  irq;
  logic        resetReq;

  int chkCount = 0;
  int badCount = 0;
  int rrCount  = 0;

  always #2 clk = ~clk;   // 250 MHz

  wdogMatchTimer u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .rdErr(rdErr),
    .irq(irq), .resetReq(resetReq)
  );

  always @(negedge clk) if (resetReq) rrCount++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    chkCount++;
    if (act !== exp) begin
      badCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic e);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData; e = rdErr;
  endtask

  task automatic tick(input int k);
    @(negedge clk);
    tickEn = 1'b1;
    repeat (k) @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic testReset();
    logic [31:0] d; logic e;
    for (int i = 0; i < 8; i++) begin
      rd(8'(i * 4), d, e);
      chk("R1 register zero after reset", d, 32'h0);
    end
    chk("R1 irq low", {28'h0, irq}, 32'h0);
    chk("R1 resetReq low", {31'h0, resetReq}, 32'h0);
  endtask

  task automatic testCount();
    logic [31:0] d; logic e;
    wr(8'h10, 32'h100);
    tick(5);
    rd(8'h10, d, e);
    chk("R2 count after load and 5 ticks", d, 32'h105);
    chk("R9 mapped read no error", {31'h0, e}, 32'h0);
    @(negedge clk);
    tickEn = 1'b1; wrEn = 1'b1; addr = 8'h10; wrData = 32'h200;
    @(negedge clk);
    tickEn = 1'b0; wrEn = 1'b0;
    rd(8'h10, d, e);
    chk("R2 load wins over tick", d, 32'h200);
  endtask

  task automatic testReadback();
    logic [31:0] d; logic e;
    for (int n = 0; n < 4; n++) wr(8'(n * 4), 32'hA5A5_0000 | 32'(n) | 32'h8000_0000);
    for (int n = 0; n < 4; n++) begin
      rd(8'(n * 4), d, e);
      chk("R10 match readback", d, 32'hA5A5_0000 | 32'(n) | 32'h8000_0000);
    end
  endtask

  task automatic testIntMask();
    logic [31:0] d; logic e;
    wr(8'h1C, 32'hFFFF_FFFF);
    rd(8'h1C, d, e);
    chk("R8 enable keeps 12 bits", d, 32'h0000_0FFF);
    wr(8'h1C, 32'h0);
  endtask

  task automatic testMatch();
    logic [31:0] d; logic e;
    wr(8'h1C, 32'h1);
    wr(8'h00, 32'h305);
    wr(8'h10, 32'h305);
    rd(8'h14, d, e);
    chk("R3 load onto match value gives no event", d, 32'h0);
    wr(8'h10, 32'h300);
    tick(4);
    chk("R3 no irq before match", {28'h0, irq}, 32'h0);
    tick(1);
    chk("R3 irq0 at match edge", {28'h0, irq}, 32'h1);
    rd(8'h14, d, e);
    chk("R3 status bit0 set", d, 32'h1);
    wr(8'h14, 32'h1);
  endtask

  task automatic testClear();
    logic [31:0] d; logic e;
    wr(8'h1C, 32'h5);
    wr(8'h00, 32'h505);
    wr(8'h08, 32'h506);
    wr(8'h10, 32'h504);
    tick(2);
    rd(8'h14, d, e);
    chk("R6 two events set", d, 32'h5);
    wr(8'h14, 32'h3);
    rd(8'h14, d, e);
    chk("R6 only set and written bits clear", d, 32'h4);
    chk("R6 irq follows status", {28'h0, irq}, 32'h4);
    wr(8'h14, 32'h4);
    chk("R6 last bit cleared", {28'h0, irq}, 32'h0);
  endtask

  task automatic testDisabled();
    logic [31:0] d; logic e;
    wr(8'h1C, 32'h1);
    wr(8'h04, 32'h402);
    wr(8'h10, 32'h400);
    tick(3);
    rd(8'h14, d, e);
    chk("R4 disabled channel records nothing", d, 32'h0);
    chk("R4 disabled channel irq low", {28'h0, irq}, 32'h0);
  endtask

  task automatic testWrap();
    logic [31:0] d; logic e;
    wr(8'h1C, 32'h4);
    wr(8'h08, 32'h0);
    wr(8'h10, 32'hFFFF_FFFE);
    tick(1);
    chk("R5 no event before wrap", {28'h0, irq}, 32'h0);
    tick(1);
    chk("R5 match at zero after wrap", {28'h0, irq}, 32'h4);
    rd(8'h10, d, e);
    chk("R2 counter wrapped to zero", d, 32'h0);
    wr(8'h14, 32'h4);
    wr(8'h1C, 32'h0);
  endtask

  task automatic testWdog();
    logic [31:0] d; logic e;
    int base;
    wr(8'h18, 32'h1);
    wr(8'h0C, 32'h700);
    wr(8'h10, 32'h6FE);
    base = rrCount;
    tick(1);
    chk("R7 no request before match", {31'h0, resetReq}, 32'h0);
    tick(1);
    chk("R7 request at match edge", {31'h0, resetReq}, 32'h1);
    @(negedge clk);
    chk("R7 request drops after one cycle", {31'h0, resetReq}, 32'h0);
    chk("R7 exactly one request cycle", 32'(rrCount - base), 32'h1);
    rd(8'h18, d, e);
    chk("R7 watchdog register cleared", d, 32'h0);
    rd(8'h14, d, e);
    chk("R4 channel 3 disabled leaves status clear", d, 32'h0);
    wr(8'h18, 32'h2);
    wr(8'h10, 32'h6FF);
    base = rrCount;
    tick(1);
    @(negedge clk);
    chk("R7 no request with arm bit 0", 32'(rrCount - base), 32'h0);
    rd(8'h18, d, e);
    chk("R7 unarmed register unchanged", d, 32'h2);
  endtask

  task automatic testUnmapped();
    logic [31:0] d; logic e;
    rd(8'h20, d, e);
    chk("R9 unmapped data zero", d, 32'h0);
    chk("R9 unmapped error flag", {31'h0, e}, 32'h1);
    @(negedge clk);
    chk("R9 error lasts one cycle", {31'h0, rdErr}, 32'h0);
    rd(8'h12, d, e);
    chk("R9 misaligned error flag", {31'h0, e}, 32'h1);
    chk("R9 misaligned data zero", d, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    badCount++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", chkCount, badCount);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testCount();
    testReadback();
    testIntMask();
    testMatch();
    testClear();
    testDisabled();
    testWrap();
    testWdog();
    testUnmapped();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", chkCount, badCount);
    $finish;
  end
endmodule